// File: doc/BRIEF.md
# Cascadable TDM Serial Audio Output Port

This block sends one stereo pair per frame on a time-division-multiplexed serial line. Several copies can be chained so that they share that line. Each copy receives a channel A and a channel B sample on a parallel interface. The samples are written with a one-cycle strobe into holding registers. At every frame start the port puts its own two 32-bit slots on the line, channel A first. After that it relays, exactly 64 bit periods later, whatever it received on its cascade input. The port closest to the consumer therefore appears first in the frame, and the upstream ports follow in chain order. The first port of a chain has its cascade input tied low, so unpopulated slots read as zero.

The port runs on one system clock. In slave mode the bit clock and the frame clock come in from outside. They are oversampled and synchronised, and the frame length is (stages_m1+1)*64 bit periods. In master mode the port divides its system clock to make the bit clock. It toggles the frame clock every 128 bit periods, which gives a fixed 256-bit frame of eight slots. A frame begins at the falling transition of the frame clock. The rising transition in the middle of the frame only marks the second half. A frame start that arrives before the expected bit count resynchronises the port at once and latches a sticky error flag.

Top module: `tdm_chain_port`

## Requirements
- R1: Data leaves MSB first. Bit 0 of a frame is launched on the first bit-clock falling edge after the frame clock goes from high to low. It is stable at the following bit-clock rising edge.
- R2: Frame bits 0..31 carry the channel A slot and bits 32..63 carry the channel B slot. Each slot is a 32-bit sample with its bit 31 sent first.
- R3: word_len selects how many upper bits of each sample are kept: 0 keeps 16, 1 keeps 20, 2 keeps 24 and 3 keeps 32. The lower bits of the slot are sent as zero.
- R4: The cascade bit sampled at the rising edge of frame bit j is sent as frame bit j+64. With cascade_in held low, all bits after the own slots are zero.
- R5: In slave mode (master_mode=0) the port follows bclk_in and fclk_in, the frame is (stages_m1+1)*64 bits, and bclk_o and fclk_o stay low.
- R6: In master mode, bclk_o has a period of 2*HALF_DIV system clocks. fclk_o toggles on a bclk_o falling edge once every 128 bit periods, and each frame begins in the low phase, so a frame is 256 bits.
- R7: A pulse on smp_valid captures smp_a and smp_b. A frame sends the pair held when the frame started, so a capture made during a frame first appears in the next frame.
- R8: A frame start that comes before the expected frame length restarts the frame at once and sets frame_err. frame_err then stays set until reset. Full-length frames and mid-frame rising frame-clock edges do not set it.
- R9: After reset, sdata_o and frame_err are 0. Until the first frame start, sdata_o relays cascade_in with the 64-bit delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the master-mode divider source |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: generate bit and frame clocks; 0: follow external clocks |
| stages_m1 | input | 3 | Slave mode: number of chained ports minus one |
| word_len | input | 2 | Kept sample width: 0=16, 1=20, 2=24, 3=32 bits |
| smp_valid | input | 1 | Capture strobe for smp_a and smp_b |
| smp_a | input | 32 | Channel A sample, MSB in bit 31 |
| smp_b | input | 32 | Channel B sample, MSB in bit 31 |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fclk_in | input | 1 | External frame clock (slave mode) |
| cascade_in | input | 1 | Serial data from the upstream port |
| bclk_o | output | 1 | Generated bit clock (master mode), low otherwise |
| fclk_o | output | 1 | Generated frame clock (master mode), low otherwise |
| sdata_o | output | 1 | TDM serial data |
| frame_err | output | 1 | Sticky early-frame flag |

## Verification
A corrupted load of the shift register shows on sdata_o in the very first bit after a frame start. A fault in the relay path stays hidden for exactly 64 bit periods and then shows as wrong upstream slot bits. The bench therefore predicts every bit of every frame, including the relayed part. A miscount of frame bits shows up only at the next frame start, as a false or missing frame_err. Because of that, each frame-length configuration is followed by a further frame and the flag is checked after it. A divider or frame-clock generator error changes the bclk_o period or the fclk_o toggle count within one bit or one half frame, and both are measured.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOT_W  = 32;
  localparam int STAGE_W = 2 * SLOT_W;

  typedef enum logic [1:0] {
    WL_16 = 2'd0,
    WL_20 = 2'd1,
    WL_24 = 2'd2,
    WL_32 = 2'd3
  } word_len_e;

  // Keeps the upper bits of a left-justified sample.
  function automatic logic [SLOT_W-1:0] slot_mask(word_len_e wl);
    logic [SLOT_W-1:0] m;
    case (wl)
      WL_16:   m = {{16{1'b1}}, {16{1'b0}}};
      WL_20:   m = {{20{1'b1}}, {12{1'b0}}};
      WL_24:   m = {{24{1'b1}}, {8{1'b0}}};
      default: m = {SLOT_W{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tdm_clk_gen.sv
module tdm_clk_gen #(
  parameter int HALF_DIV  = 4,
  parameter int FCLK_HALF = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk,
  output logic fclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GW = (FCLK_HALF > 1) ? $clog2(FCLK_HALF) : 1;
  localparam logic [DW-1:0] DLAST = DW'(HALF_DIV - 1);
  localparam logic [GW-1:0] GLAST = GW'(FCLK_HALF - 1);

  logic [DW-1:0] div_q, div_d;
  logic [GW-1:0] half_q, half_d;
  logic          bclk_q, bclk_d;
  logic          fclk_q, fclk_d;
  logic          tick;

  always_comb begin
    tick   = en && (div_q == DLAST);
    div_d  = div_q;
    half_d = half_q;
    bclk_d = bclk_q;
    fclk_d = fclk_q;
    if (!en) begin
      div_d  = '0;
      half_d = GLAST;
      bclk_d = 1'b0;
      fclk_d = 1'b1;
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        bclk_d = ~bclk_q;
        if (bclk_q) begin
          // falling edge of the bit clock: count half-frame bits
          if (half_q == GLAST) begin
            half_d = '0;
            fclk_d = ~fclk_q;
          end else begin
            half_d = half_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      half_q <= GLAST;
      bclk_q <= 1'b0;
      fclk_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      half_q <= half_d;
      bclk_q <= bclk_d;
      fclk_q <= fclk_d;
    end
  end

  assign bclk     = bclk_q;
  assign fclk     = fclk_q;
  assign rise_evt = tick & ~bclk_q;
  assign fall_evt = tick & bclk_q;

  // R6: the generated frame clock only moves together with a bit-clock fall
  a_r6_fclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(fclk_q)) |-> $fell(bclk_q));
endmodule

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fclk_in,
  input  logic cas_in,
  output logic rise_evt,
  output logic fall_evt,
  output logic fclk_s,
  output logic cas_s
);
  localparam int LANES = 3;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] synced;
  logic             b_last_q;

  assign raw = {cas_in, fclk_in, bclk_in};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= {q[STAGES-2:0], raw[l]};
    end
    assign synced[l] = q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_last_q <= 1'b0;
    else        b_last_q <= synced[0];
  end

  assign rise_evt = synced[0] & ~b_last_q;
  assign fall_evt = ~synced[0] & b_last_q;
  assign fclk_s   = synced[1];
  assign cas_s    = synced[2];
endmodule

// File: rtl/tdm_shift_core.sv
module tdm_shift_core
  import tdm_pkg::*;
#(
  parameter int MAX_STAGES   = 8,
  parameter int MASTER_SLOTS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   master_mode,
  input  logic [((MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1)-1:0] stages_m1,
  input  word_len_e              word_len,
  input  logic                   smp_valid,
  input  logic [SLOT_W-1:0]      smp_a,
  input  logic [SLOT_W-1:0]      smp_b,
  input  logic                   rise_evt,
  input  logic                   fall_evt,
  input  logic                   fclk_smp,
  input  logic                   cas_smp,
  output logic                   sdata,
  output logic                   frame_err
);
  localparam int MASTER_LEN = MASTER_SLOTS * SLOT_W;
  localparam int MAX_LEN    = (MAX_STAGES * STAGE_W > MASTER_LEN) ? MAX_STAGES * STAGE_W : MASTER_LEN;
  localparam int CW         = $clog2(MAX_LEN) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [SLOT_W-1:0]  hold_a_q, hold_a_d, hold_b_q, hold_b_d;
  logic [STAGE_W-1:0] sr_q, sr_d;
  logic [CW-1:0]      cnt_q, cnt_d, frame_len;
  logic               cas_q, cas_d;
  logic               fprev_q, fprev_d;
  logic               pend_q, pend_d;
  logic               synced_q, synced_d;
  logic               err_q, err_d;
  logic               start;

  always_comb begin
    frame_len = master_mode ? CW'(MASTER_LEN)
                            : CW'((int'(stages_m1) + 1) * STAGE_W);
    start     = fall_evt && pend_q;
    hold_a_d  = hold_a_q;
    hold_b_d  = hold_b_q;
    sr_d      = sr_q;
    cnt_d     = cnt_q;
    cas_d     = cas_q;
    fprev_d   = fprev_q;
    pend_d    = pend_q;
    synced_d  = synced_q;
    err_d     = err_q;

    if (smp_valid) begin
      hold_a_d = smp_a & slot_mask(word_len);
      hold_b_d = smp_b & slot_mask(word_len);
    end

    if (rise_evt) begin
      cas_d   = cas_smp;
      fprev_d = fclk_smp;
      if (fprev_q && !fclk_smp) pend_d = 1'b1;
    end

    if (start) begin
      sr_d     = {hold_a_q, hold_b_q};
      cnt_d    = '0;
      pend_d   = 1'b0;
      synced_d = 1'b1;
      if (synced_q && (cnt_q < frame_len - CW'(1))) err_d = 1'b1;
    end else if (fall_evt) begin
      sr_d = {sr_q[STAGE_W-2:0], cas_q};
      if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
      sr_q     <= '0;
      cnt_q    <= '0;
      cas_q    <= 1'b0;
      fprev_q  <= 1'b0;
      pend_q   <= 1'b0;
      synced_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      hold_a_q <= hold_a_d;
      hold_b_q <= hold_b_d;
      sr_q     <= sr_d;
      cnt_q    <= cnt_d;
      cas_q    <= cas_d;
      fprev_q  <= fprev_d;
      pend_q   <= pend_d;
      synced_q <= synced_d;
      err_q    <= err_d;
    end
  end

  assign sdata     = sr_q[STAGE_W-1];
  assign frame_err = err_q;

  // R8: the framing flag never clears on its own
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R1: the first bit of a frame is the MSB of the held channel A sample
  a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && pend_q) |=> (sdata == $past(hold_a_q[SLOT_W-1])));

  // R5: edge events from the selected clock source never coincide
  a_r5_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
endmodule

// File: rtl/tdm_chain_port.sv
module tdm_chain_port
  import tdm_pkg::*;
#(
  parameter int HALF_DIV     = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int MAX_STAGES   = 8,
  parameter int MASTER_SLOTS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   master_mode,
  input  logic [((MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1)-1:0] stages_m1,
  input  logic [1:0]             word_len,
  input  logic                   smp_valid,
  input  logic [31:0]            smp_a,
  input  logic [31:0]            smp_b,
  input  logic                   bclk_in,
  input  logic                   fclk_in,
  input  logic                   cascade_in,
  output logic                   bclk_o,
  output logic                   fclk_o,
  output logic                   sdata_o,
  output logic                   frame_err
);
  localparam int FCLK_HALF = MASTER_SLOTS * SLOT_W / 2;

  logic g_bclk, g_fclk, g_rise, g_fall;
  logic s_rise, s_fall, s_fclk, s_cas;
  logic rise_sel, fall_sel, fclk_sel;

  tdm_clk_gen #(
    .HALF_DIV  (HALF_DIV),
    .FCLK_HALF (FCLK_HALF)
  ) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (master_mode),
    .bclk     (g_bclk),
    .fclk     (g_fclk),
    .rise_evt (g_rise),
    .fall_evt (g_fall)
  );

  tdm_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_in  (bclk_in),
    .fclk_in  (fclk_in),
    .cas_in   (cascade_in),
    .rise_evt (s_rise),
    .fall_evt (s_fall),
    .fclk_s   (s_fclk),
    .cas_s    (s_cas)
  );

  assign rise_sel = master_mode ? g_rise : s_rise;
  assign fall_sel = master_mode ? g_fall : s_fall;
  assign fclk_sel = master_mode ? g_fclk : s_fclk;

  tdm_shift_core #(
    .MAX_STAGES   (MAX_STAGES),
    .MASTER_SLOTS (MASTER_SLOTS)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .stages_m1   (stages_m1),
    .word_len    (word_len_e'(word_len)),
    .smp_valid   (smp_valid),
    .smp_a       (smp_a),
    .smp_b       (smp_b),
    .rise_evt    (rise_sel),
    .fall_evt    (fall_sel),
    .fclk_smp    (fclk_sel),
    .cas_smp     (s_cas),
    .sdata       (sdata_o),
    .frame_err   (frame_err)
  );

  assign bclk_o = g_bclk;
  assign fclk_o = master_mode ? g_fclk : 1'b0;

  // R5: a port in slave mode drives no bit clock of its own
  a_r5_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !$past(master_mode)) |-> (bclk_o == 1'b0 && fclk_o == 1'b0));
endmodule

// File: tb/sim_tdm_chain_port.sv
module sim_tdm_chain_port;
  localparam int HALF_DIV = 4;
  localparam int HB       = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        master_mode;
  logic [2:0]  stages_m1;
  logic [1:0]  word_len;
  logic        smp_valid;
  logic [31:0] smp_a, smp_b;
  logic        bclk_in, fclk_in, cascade_in;
  logic        bclk_o, fclk_o, sdata_o, frame_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] mdl_a = '0;
  logic [31:0] mdl_b = '0;

  always #5 clk = ~clk;

  tdm_chain_port #(.HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .stages_m1(stages_m1),
    .word_len(word_len), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
    .bclk_in(bclk_in), .fclk_in(fclk_in), .cascade_in(cascade_in),
    .bclk_o(bclk_o), .fclk_o(fclk_o), .sdata_o(sdata_o), .frame_err(frame_err)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] keep_upper(logic [31:0] x, int wl);
    int nb = (wl == 3) ? 32 : 16 + 4 * wl;
    logic [31:0] m = '0;
    for (int i = 0; i < nb; i++) m[31-i] = 1'b1;
    return x & m;
  endfunction

  // one-clock capture strobe; the model keeps what the port should hold
  task automatic strobe(logic [31:0] na, logic [31:0] nb);
    smp_a = na; smp_b = nb; smp_valid = 1'b1;
    mdl_a = keep_upper(na, int'(word_len));
    mdl_b = keep_upper(nb, int'(word_len));
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // idle bit periods before the first slave frame; last one drops fclk
  task automatic slave_idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bclk_in = 1'b0; cascade_in = 1'b0;
      fclk_in = (k == n - 1) ? 1'b0 : 1'b1;
      repeat (HB - 1) @(negedge clk);
      check("R9 idle output", int'(sdata_o), 0);
      bclk_in = 1'b1;
      repeat (HB) @(negedge clk);
    end
  endtask

  // one slave frame of len bits; period j drives the frame clock for bit j+1
  task automatic slave_frame(int len, int st, bit use_cas, int strobe_at,
                             logic [31:0] na, logic [31:0] nb, string tag);
    logic [63:0] own;
    logic up[$];
    own = {mdl_a, mdl_b};
    for (int j = 0; j < len; j++) begin
      logic cb;
      logic expb;
      @(negedge clk);
      cb = use_cas ? 1'($urandom) : 1'b0;
      up.push_back(cb);
      bclk_in = 1'b0; cascade_in = cb;
      fclk_in = (j == len - 1) ? 1'b0 : ((j < len / 2 - 1) ? 1'b0 : 1'b1);
      if (j == 1) stages_m1 = 3'(st);
      if (j == strobe_at) strobe(na, nb);
      else @(negedge clk);
      repeat (HB - 2) @(negedge clk);
      expb = (j < 64) ? own[63-j] : up[j-64];
      if (j < 32)      check({tag, " R1 R2 chA slot"}, int'(sdata_o), int'(expb));
      else if (j < 64) check({tag, " R2 chB slot"}, int'(sdata_o), int'(expb));
      else             check({tag, " R4 relay"}, int'(sdata_o), int'(expb));
      @(negedge clk);
      bclk_in = 1'b1;
      repeat (HB) @(negedge clk);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished at %0t", $time);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; master_mode = 1'b0; stages_m1 = 3'd0; word_len = 2'd3;
    smp_valid = 1'b0; smp_a = '0; smp_b = '0;
    bclk_in = 1'b0; fclk_in = 1'b1; cascade_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 reset sdata", int'(sdata_o), 0);
    check("R9 reset frame_err", int'(frame_err), 0);
    check("R5 reset bclk_o", int'(bclk_o), 0);
    check("R5 reset fclk_o", int'(fclk_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // slave, single stage, full 32-bit words
    strobe(32'hA5C3_0F81, 32'h1234_5678);
    slave_idle(4);
    slave_frame(64, 0, 1'b0, 10, 32'h8000_0001, 32'hFFFF_0000, "R5 N1 R7 midframe");
    slave_frame(64, 0, 1'b0, -1, '0, '0, "R7 next frame");
    check("R5 slave bclk_o low", int'(bclk_o), 0);

    // three stages, 16-bit words, live cascade
    word_len = 2'd0;
    slave_frame(192, 2, 1'b1, 20, 32'hDEAD_BEEF, 32'h0123_ABCD, "R3 wl16 N3");
    word_len = 2'd1;
    slave_frame(192, 2, 1'b1, 70, 32'hFFFF_FFFF, 32'h7654_3210, "R3 wl20 N3");
    word_len = 2'd2;
    slave_frame(512, 7, 1'b1, 100, 32'hC0FF_EE11, 32'h5A5A_A5A5, "R3 wl24 N8");
    slave_frame(512, 7, 1'b1, -1, '0, '0, "R3 wl24 N8 out");
    slave_frame(128, 1, 1'b1, -1, '0, '0, "R5 N2");
    check("R8 no error on full frames", int'(frame_err), 0);

    // early frame start after 40 bits of a 128-bit frame
    slave_frame(40, 1, 1'b1, -1, '0, '0, "R8 short frame");
    check("R8 no flag before next start", int'(frame_err), 0);
    slave_frame(128, 1, 1'b1, -1, '0, '0, "R8 resync");
    check("R8 early start flagged", int'(frame_err), 1);
    slave_frame(128, 1, 1'b0, -1, '0, '0, "R8 sticky");
    check("R8 flag sticky", int'(frame_err), 1);

    // master mode: generated clocks, 256-bit frame
    rst_n = 1'b0; master_mode = 1'b1; word_len = 2'd2; bclk_in = 1'b0; cascade_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 flag cleared by reset", int'(frame_err), 0);
    rst_n = 1'b1;
    strobe(32'h89AB_CDEF, 32'hF00D_0042);
    begin
      logic pb, pf, pend, in_frame;
      logic [63:0] own;
      logic up[$];
      int j, cyc, last_rise, falls_since, nfr;
      pb = bclk_o; pf = fclk_o; pend = 1'b0; in_frame = 1'b0;
      own = '0; j = 0; cyc = 0; last_rise = -1; falls_since = -1; nfr = 0;
      while (nfr < 3) begin
        if (bclk_o && !pb) begin
          if (last_rise >= 0) check("R6 bclk_o period", cyc - last_rise, 2 * HALF_DIV);
          last_rise = cyc;
          if (in_frame) begin
            if (j < 64) check("R6 R2 master own slot", int'(sdata_o), int'(own[63-j]));
            else        check("R6 R4 master relay", int'(sdata_o), int'(up[j-64]));
          end
        end
        if (!bclk_o && pb) begin
          if (pend) begin
            j = 0; in_frame = 1'b1; own = {mdl_a, mdl_b}; pend = 1'b0; up.delete(); nfr++;
            check("R6 frame starts with fclk_o low", int'(fclk_o), 0);
          end else begin
            j++;
          end
          if (fclk_o != pf) begin
            if (falls_since >= 0) check("R6 fclk_o half frame", falls_since + 1, 128);
            falls_since = 0;
            if (!fclk_o) pend = 1'b1;
          end else if (falls_since >= 0) begin
            falls_since++;
          end
          if (in_frame) begin
            logic cb;
            cb = 1'($urandom);
            cascade_in = cb;
            up.push_back(cb);
          end
        end
        pb = bclk_o; pf = fclk_o; cyc++;
        @(negedge clk);
      end
    end
    check("R8 master full frames clean", int'(frame_err), 0);
    finish_run();
  end
endmodule